// File: doc/BRIEF.md
# Multichannel DDR Serial Sample Deserializer

This block receives a group of serial data lanes from a multichannel converter, one lane per channel, and turns them back into parallel sample words. Each lane carries one 12-bit word per sample period. The lanes are clocked by a bit clock at six times the sample rate, and bits are taken on both of its edges. That gives twelve half-cycle slots per sample period. A frame signal at the sample rate rises on the first bit of every word, and the block uses it to find word boundaries.

Both edges are captured into registers, and each pair of slots is then handled on the rising edge of the bit clock. The older slot is the one taken on the rising edge and the newer one is taken on the falling edge. The block tracks the distance between frame rising transitions in half-cycles. It declares lock when two transitions lie exactly one word apart. On every correctly spaced boundary it presents all lane words together with one common strobe. A runtime input selects whether the first bit received is the word's most or least significant bit.

Top module: `mc_lane_deser`

## Requirements
- R1: While `rst_i` is high at a rising bit-clock edge, `valid_o`, `locked_o` and every word on `words_o` are cleared to zero, together with the internal history and the half-cycle counter.
- R2: A word boundary is the first half-cycle slot in which `frame_i` is sampled high after being sampled low. This also applies when that slot is a rising-edge sample.
- R3: With `lsb_first_i` = 0, the first bit received after a boundary becomes bit 11 of the word and the last bit becomes bit 0.
- R4: With `lsb_first_i` = 1, the first bit received after a boundary becomes bit 0 of the word and the last bit becomes bit 11.
- R5: `valid_o` is high for exactly one bit-clock cycle for each boundary that lies exactly 12 half-cycles after the previous boundary. The first boundary after reset never strobes.
- R6: `locked_o` rises in the same cycle as the first strobe and stays high while every boundary keeps 12-half-cycle spacing.
- R7: A boundary spaced shorter or longer than 12 half-cycles, or the absence of a boundary at the 12th half-cycle, clears `locked_o`. A wrongly spaced boundary produces no strobe. The next correctly spaced boundary locks again.
- R8: `words_o` holds its value in every cycle in which `valid_o` is low.
- R9: Boundaries that fall on falling-edge samples are handled the same way as rising-edge ones, with no loss of bits.
- R10: Lane n fills `words_o[n*12 +: 12]` from its own serial input only. All lanes share one strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_bit_i | input | 1 | Bit clock, six times the sample rate; data is sampled on both edges |
| rst_i | input | 1 | Synchronous reset, active high |
| frame_i | input | 1 | Sample-rate frame signal, rising on the first bit of each word |
| lane_i | input | LANES | Serial data, one bit per lane |
| lsb_first_i | input | 1 | 0: first bit received is the MSB; 1: it is the LSB |
| words_o | output | LANES*WORD_W | Assembled words, lane n at bits n*WORD_W upward |
| valid_o | output | 1 | One-cycle strobe marking a fresh set of words |
| locked_o | output | 1 | Frame spacing has been confirmed |

## Verification
Two functions can land in the same rising-edge cycle. One is the spacing judgement that ends the previous word and decides whether it is strobed or discarded. The other is the start of the next word, which may begin in either half of that same cycle. Both are provoked by randomly shifting the stream by an odd number of slots and by perturbing frame periods by one or two half-cycles. A slot-by-slot reference model in the bench predicts the strobe, the lock flag and every lane word for each cycle, and these are compared against the outputs.

// File: rtl/ddrdes_pkg.sv
`timescale 1ns/1ps
package ddrdes_pkg;
   // bit-reverse a word of the given width
   function automatic logic [31:0] flip_bits(input logic [31:0] v, input int w);
      logic [31:0] r;
      r = '0;
      for (int i = 0; i < 32; i++) begin
         if (i < w) r[w-1-i] = v[i];
      end
      return r;
   endfunction
endpackage

// File: rtl/ddr_capture.sv
`timescale 1ns/1ps
module ddr_capture #(
   parameter int W = 9
) (
   input  logic         clk_i,
   input  logic         rst_i,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] rise_o,
   output logic [W-1:0] fall_o
);
   // rise_o holds the older slot of a pair, fall_o the newer one
   always_ff @(posedge clk_i) begin
      if (rst_i) rise_o <= '0;
      else       rise_o <= d_i;
   end

   always_ff @(negedge clk_i) begin
      if (rst_i) fall_o <= '0;
      else       fall_o <= d_i;
   end
endmodule

// File: rtl/frame_tracker.sv
`timescale 1ns/1ps
module frame_tracker #(
   parameter int WORD_W = 12
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic f_rise_i,
   input  logic f_fall_i,
   output logic edge_late_o,
   output logic load_o,
   output logic valid_o,
   output logic locked_o
);
   localparam int CNT_W   = $clog2(2 * WORD_W + 4);
   localparam int CNT_MAX = (1 << CNT_W) - 1;

   logic             prev_f;
   logic             have_ref;
   logic [CNT_W-1:0] slot_cnt;
   logic             hit_early, hit_late, hit_any, overdue;
   logic [CNT_W:0]   gap;

   assign hit_early   = !prev_f && f_rise_i;
   assign hit_late    = !f_rise_i && f_fall_i;
   assign hit_any     = hit_early || hit_late;
   assign gap         = {1'b0, slot_cnt} + (hit_early ? 1 : 2);
   assign load_o      = hit_any && have_ref && (gap == WORD_W);
   assign edge_late_o = hit_late;
   assign overdue     = !hit_any && (({1'b0, slot_cnt} + 2) >= WORD_W);

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         prev_f   <= 1'b0;
         have_ref <= 1'b0;
         slot_cnt <= '0;
         valid_o  <= 1'b0;
         locked_o <= 1'b0;
      end else begin
         prev_f  <= f_fall_i;
         valid_o <= load_o;
         if (hit_any) begin
            have_ref <= 1'b1;
            slot_cnt <= hit_early ? CNT_W'(1) : CNT_W'(0);
            locked_o <= load_o;
         end else begin
            if (slot_cnt < CNT_W'(CNT_MAX - 1)) slot_cnt <= slot_cnt + CNT_W'(2);
            else                                 slot_cnt <= CNT_W'(CNT_MAX);
            if (overdue) locked_o <= 1'b0;
         end
      end
   end

   AST_STROBE_LOCKED: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |-> locked_o); // R6
   AST_LOCK_WITH_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
      $rose(locked_o) |-> valid_o); // R6
   AST_STROBE_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
      valid_o |=> !valid_o); // R5
   AST_UNLOCK_NO_STROBE: assert property (@(posedge clk_i) disable iff (rst_i)
      $fell(locked_o) |-> !valid_o); // R7
endmodule

// File: rtl/lane_assembler.sv
`timescale 1ns/1ps
module lane_assembler
   import ddrdes_pkg::*;
#(
   parameter int WORD_W = 12
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              bit_rise_i,
   input  logic              bit_fall_i,
   input  logic              edge_late_i,
   input  logic              load_i,
   input  logic              lsb_first_i,
   output logic [WORD_W-1:0] word_o
);
   localparam int HIST_W = WORD_W + 2;

   logic [HIST_W-1:0] hist;
   logic [HIST_W-1:0] hist_nx;
   logic [WORD_W-1:0] in_order;
   logic [WORD_W-1:0] arranged;
   logic [31:0]       flipped;

   assign hist_nx  = {hist[WORD_W-1:0], bit_rise_i, bit_fall_i};
   // boundary on newer slot: word ends one slot later in the history
   assign in_order = edge_late_i ? hist_nx[WORD_W:1] : hist_nx[WORD_W+1:2];
   assign flipped  = flip_bits(32'(in_order), WORD_W);
   assign arranged = lsb_first_i ? flipped[WORD_W-1:0] : in_order;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         hist   <= '0;
         word_o <= '0;
      end else begin
         hist <= hist_nx;
         if (load_i) word_o <= arranged;
      end
   end

   AST_WORD_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
      !load_i |=> $stable(word_o)); // R8
endmodule

// File: rtl/mc_lane_deser.sv
`timescale 1ns/1ps
module mc_lane_deser #(
   parameter int LANES  = 8,
   parameter int WORD_W = 12
) (
   input  logic                      clk_bit_i,
   input  logic                      rst_i,
   input  logic                      frame_i,
   input  logic [LANES-1:0]          lane_i,
   input  logic                      lsb_first_i,
   output logic [LANES*WORD_W-1:0]   words_o,
   output logic                      valid_o,
   output logic                      locked_o
);
   localparam int CAP_W = LANES + 1;

   generate
      if (WORD_W % 2 != 0) begin : g_bad_width
         $error("WORD_W must be even for two bits per clock");
      end
      if (WORD_W < 4 || WORD_W > 32) begin : g_bad_range
         $error("WORD_W must lie in 4..32");
      end
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   logic [CAP_W-1:0] cap_rise, cap_fall;
   logic             edge_late, load;

   ddr_capture #(.W(CAP_W)) cap_i (
      .clk_i  (clk_bit_i),
      .rst_i  (rst_i),
      .d_i    ({frame_i, lane_i}),
      .rise_o (cap_rise),
      .fall_o (cap_fall)
   );

   frame_tracker #(.WORD_W(WORD_W)) trk_i (
      .clk_i       (clk_bit_i),
      .rst_i       (rst_i),
      .f_rise_i    (cap_rise[LANES]),
      .f_fall_i    (cap_fall[LANES]),
      .edge_late_o (edge_late),
      .load_o      (load),
      .valid_o     (valid_o),
      .locked_o    (locked_o)
   );

   for (genvar n = 0; n < LANES; n++) begin : g_lane
      lane_assembler #(.WORD_W(WORD_W)) asm_i (
         .clk_i       (clk_bit_i),
         .rst_i       (rst_i),
         .bit_rise_i  (cap_rise[n]),
         .bit_fall_i  (cap_fall[n]),
         .edge_late_i (edge_late),
         .load_i      (load),
         .lsb_first_i (lsb_first_i),
         .word_o      (words_o[n*WORD_W +: WORD_W])
      );
   end

   AST_RESET_QUIET: assert property (@(posedge clk_bit_i)
      $past(rst_i) |-> (!valid_o && !locked_o && words_o == '0)); // R1
endmodule

// File: tb/mc_lane_deser_tb_top.sv
`timescale 1ns/1ps
module mc_lane_deser_tb_top;
   localparam int LN = 8;
   localparam int WW = 12;

   typedef struct packed {
      logic          v;
      logic          l;
      logic [LN*WW-1:0] w;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             frame = 1'b0;
   logic [LN-1:0]    lanes = '0;
   logic             lsb_first = 1'b0;
   logic [LN*WW-1:0] words;
   logic             valid, locked;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   mc_lane_deser #(.LANES(LN), .WORD_W(WW)) dut_i (
      .clk_bit_i   (clk),
      .rst_i       (rst),
      .frame_i     (frame),
      .lane_i      (lanes),
      .lsb_first_i (lsb_first),
      .words_o     (words),
      .valid_o     (valid),
      .locked_o    (locked)
   );

   // reference model state
   logic [WW-1:0]    m_hist [LN];
   bit               m_prev, m_ref, m_lock;
   int               m_dist;
   logic [LN*WW-1:0] m_words;
   exp_t             q[$];
   string            tq[$];
   string            cur_tag = "R2/R3";
   bit               pend_f;
   logic [LN-1:0]    pend_d;
   bit               pend_ok;

   function automatic logic [WW-1:0] rev12(input logic [WW-1:0] v);
      logic [WW-1:0] r;
      for (int i = 0; i < WW; i++) r[WW-1-i] = v[i];
      return r;
   endfunction

   task automatic check(input bit ok, input string tag, input logic [LN*WW-1:0] act,
                        input logic [LN*WW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int l = 0; l < LN; l++) m_hist[l] = '0;
      m_prev = 0; m_ref = 0; m_lock = 0; m_dist = 0; m_words = '0;
      q.delete(); tq.delete(); pend_ok = 0;
   endtask

   function automatic bit model_slot(input bit f, input logic [LN-1:0] d);
      bit v = 0;
      if (m_dist < 60) m_dist++;
      if (!m_prev && f) begin
         v = m_ref && (m_dist == WW);
         m_lock = v;
         if (v) begin
            for (int l = 0; l < LN; l++)
               m_words[l*WW +: WW] = lsb_first ? rev12(m_hist[l]) : m_hist[l];
         end
         m_ref = 1; m_dist = 0;
      end else if (m_dist == WW) begin
         m_lock = 0; // R7 missing boundary
      end
      for (int l = 0; l < LN; l++) m_hist[l] = {m_hist[l][WW-2:0], d[l]};
      m_prev = f;
      return v;
   endfunction

   task automatic check_oldest();
      exp_t  e;
      string t;
      if (q.size() >= 2) begin
         e = q.pop_front();
         t = tq.pop_front();
         check(valid === e.v, "R5", {95'b0, valid}, {95'b0, e.v});
         check(locked === e.l, "R6/R7", {95'b0, locked}, {95'b0, e.l});
         check(words === e.w, e.v ? t : "R8", words, e.w);
      end
   endtask

   task automatic drive_pair(input bit f0, input logic [LN-1:0] d0,
                             input bit f1, input logic [LN-1:0] d1);
      exp_t e;
      bit   v0, v1;
      @(negedge clk);
      check_oldest();
      #1 frame = f0; lanes = d0;
      @(posedge clk);
      #1 frame = f1; lanes = d1;
      v0 = model_slot(f0, d0);
      v1 = model_slot(f1, d1);
      e.v = v0 | v1; e.l = m_lock; e.w = m_words;
      q.push_back(e); tq.push_back(cur_tag);
   endtask

   task automatic put_slot(input bit f, input logic [LN-1:0] d);
      if (pend_ok) begin
         drive_pair(pend_f, pend_d, f, d);
         pend_ok = 0;
      end else begin
         pend_f = f; pend_d = d; pend_ok = 1;
      end
   endtask

   // lead: idle slots before the first frame; jit: percent of perturbed periods;
   // gap_at: frame index whose period is stretched to simulate a missing boundary
   task automatic run_stream(input int nfr, input int lead, input int jit, input int gap_at);
      for (int s = 0; s < lead; s++) put_slot(0, LN'($urandom));
      for (int k = 0; k < nfr; k++) begin
         int p = WW;
         if (jit > 0 && int'($urandom % 100) < jit) begin
            int r = int'($urandom % 4);
            p = (r == 0) ? WW - 2 : (r == 1) ? WW - 1 : (r == 2) ? WW + 1 : WW + 2;
         end
         if (k == gap_at) p = 2 * WW + 3;
         for (int s = 0; s < p; s++) put_slot(s < (p / 2), LN'($urandom));
      end
      for (int s = 0; s < 6; s++) put_slot(0, '0);
      if (pend_ok) put_slot(0, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      #1 rst = 1; frame = 0; lanes = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(valid === 1'b0 && locked === 1'b0 && words === '0, "R1",
            {words[LN*WW-1:2], valid, locked}, '0);
      #1 rst = 0;
      model_reset();
   endtask

   initial begin
      #(10 * 100000);
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'h5EED_0A17));
      model_reset();
      do_reset();

      // R2 R3 R10: rising-half boundaries, most significant bit first
      lsb_first = 0; cur_tag = "R2/R3/R10";
      run_stream(20, 4, 0, -1);

      // R4: least significant bit first
      do_reset();
      lsb_first = 1; cur_tag = "R4/R10";
      run_stream(20, 6, 0, -1);

      // R9: odd lead puts every boundary on a falling-half sample
      do_reset();
      lsb_first = 0; cur_tag = "R9/R3";
      run_stream(20, 5, 0, -1);
      do_reset();
      lsb_first = 1; cur_tag = "R9/R4";
      run_stream(15, 7, 0, -1);

      // R7: perturbed spacing, both halves, random order
      for (int t = 0; t < 6; t++) begin
         do_reset();
         lsb_first = $urandom % 2;
         cur_tag = "R7/R5";
         run_stream(30, int'($urandom % 9), 25, -1);
      end

      // R7: a missing boundary in the middle, then recovery
      do_reset();
      lsb_first = 0; cur_tag = "R7/R6";
      run_stream(16, 4, 0, 7);

      // R1: reset straight after traffic clears the held words
      lsb_first = 0; cur_tag = "R1/R3";
      run_stream(5, 2, 0, -1);
      do_reset();

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule